// File: doc/BRIEF.md
# Encoder-Link Command Dispatcher

This block sits between a serial peripheral interface (SPI) slave shift register and an absolute-encoder frame reader. Every transaction from the host carries one 32-bit datagram. The shift register hands over the received word with a one-cycle strobe. The dispatcher decodes only the most significant byte of that word, which is the first byte on the wire. It then either starts an encoder read, answers a version or protocol query, or drops the word. Answers are placed in a transmit FIFO as tagged 32-bit words, and the shift register takes one word per later transaction. A data-ready flag tells the host that answers are waiting.

An encoder read is a handshake with the frame reader. A one-cycle launch strobe starts the read. The reader later returns a done strobe together with the 13-bit Gray position, the error and warning pair, the received CRC, the locally computed CRC and the number of clock edges used. The dispatcher converts the position to binary and queues four tagged words. The host collects these words with all-zero dummy datagrams. The last collecting transaction may already carry the next real command.

The controller has six states:
- IDLE accepts commands.
- WAIT_ENC waits for the reader to finish.
- Q_RAW, Q_BIN, Q_STAT and Q_EDGE each push one answer word, in that order, then return to IDLE.

The transitions are:
- launch: IDLE to WAIT_ENC.
- done: WAIT_ENC to Q_RAW.
- step: each Q_ state to the next one, and Q_EDGE back to IDLE.

Version and protocol answers are pushed straight from IDLE without a state change.

Top module: `enclink_cmd_dispatch`

## Requirements
- R1: After reset, data_ready is low, tx_word is 0x00000000 and enc_launch is low.
- R2: A datagram whose top byte is 0x80 is a read command. It raises enc_launch in the same cycle as rx_strobe, for exactly one cycle, when it arrives in IDLE with the FIFO empty.
- R3: When enc_done arrives in WAIT_ENC, four words are queued in this order:
  - `{0x10, 0x00, Gray position zero-extended to 16 bits}`
  - `{0x20, 0x00, binary position zero-extended to 16 bits}`
  - `{0x70, flags, received CRC, computed CRC}`, where the flags byte holds error in bit 1 and warning in bit 0, and each CRC sits in the low 6 bits of its byte.
  - `{0x71, 0x00, 0x00, edge count}`
- R4: Binary position bit 12 equals Gray bit 12. Each lower binary bit equals the binary bit above it XOR the Gray bit at the same position.
- R5: Top byte 0xFF queues the single word `{0xFF, 0x00, major version, minor version}`, with the defaults 0x01 and 0x00.
- R6: Top byte 0xFE queues the single word 0x42495353.
- R7: data_ready is high exactly while at least one word is queued. While the FIFO is empty, tx_word is 0x00000000.
- R8: tx_word shows the oldest queued word. Each tx_pop removes exactly one word, in first-in first-out order. A pop and a new command in the same cycle both take effect.
- R9: The all-zero dummy datagram, and any top byte other than 0x80, 0xFF and 0xFE, queues nothing and starts nothing, whatever the low 24 bits hold.
- R10: A command arriving outside IDLE is discarded. A read command arriving while the FIFO holds words is also discarded, so no second response is created.
- R11: A query arriving while the FIFO is full is discarded, and the FIFO never overflows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_strobe | input | 1 | Received datagram valid for one cycle |
| rx_word | input | 32 | Received datagram, top byte first on the wire |
| tx_pop | input | 1 | Shift register takes the current tx_word |
| tx_word | output | 32 | Oldest queued answer, or zero when empty |
| data_ready | output | 1 | Answer words are waiting |
| enc_launch | output | 1 | One-cycle request to read the encoder |
| enc_done | input | 1 | Encoder frame finished, fields valid |
| enc_gray | input | 13 | Received Gray position |
| enc_flags | input | 2 | Error (bit 1) and warning (bit 0) bits |
| enc_crc_rx | input | 6 | CRC as received |
| enc_crc_calc | input | 6 | CRC computed over the frame |
| enc_edges | input | 8 | Clock edges used for the frame |

## Verification
The assertions check on every cycle that:
- enc_launch lasts one cycle and never fires while answers are pending;
- an empty FIFO drives zero onto tx_word;
- each lone pop lowers the occupancy by one;
- the FIFO is never written when full;
- the binary position re-encodes to the captured Gray value.

Word content, tag order, the dummy and unknown-command cases, commands discarded while a read is in flight, and a command riding on the last read-out transaction can only be shown by the bench. It compares the popped words against values it builds itself, over a random mix of commands and frame contents.

// File: rtl/enclink_pkg.sv
package enclink_pkg;
    localparam logic [7:0] CMD_READ    = 8'h80;
    localparam logic [7:0] CMD_VERSION = 8'hFF;
    localparam logic [7:0] CMD_PROTO   = 8'hFE;

    localparam logic [7:0] TAG_RAW  = 8'h10;
    localparam logic [7:0] TAG_BIN  = 8'h20;
    localparam logic [7:0] TAG_STAT = 8'h70;
    localparam logic [7:0] TAG_EDGE = 8'h71;

    localparam logic [31:0] PROTO_WORD = 32'h4249_5353;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_ENC,
        ST_Q_RAW,
        ST_Q_BIN,
        ST_Q_STAT,
        ST_Q_EDGE
    } disp_state_t;
endpackage

// File: rtl/enclink_gray_to_bin.sv
module enclink_gray_to_bin #(
    parameter int W = 13
) (
    input  logic [W-1:0] gray,
    output logic [W-1:0] bin
);
    always_comb begin
        bin[W-1] = gray[W-1];
        for (int i = W - 2; i >= 0; i--) begin
            bin[i] = bin[i+1] ^ gray[i];
        end
    end

    // R4: re-encoding the result must give back the input
    always_comb begin
        assert_reencode_R4: assert ((bin ^ (bin >> 1)) == gray)
            else $error("binary position does not re-encode to the Gray input");
    end
endmodule

// File: rtl/enclink_reply_fifo.sv
module enclink_reply_fifo #(
    parameter int DEPTH = 8,
    parameter int DW    = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic          empty,
    output logic          full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          do_pop;

    assign empty  = (count == '0);
    assign full   = (count == CW'(DEPTH));
    assign do_pop = pop && !empty;
    assign head   = empty ? '0 : mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push)   wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop) rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            if (push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !push) count <= count - 1'b1;
        end
    end

    assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full)
        else $error("write into a full reply FIFO");

    assert_pop_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && !empty) |=> (count == $past(count) - 1'b1))
        else $error("pop did not remove exactly one word");
endmodule

// File: rtl/enclink_cmd_dispatch.sv
module enclink_cmd_dispatch
    import enclink_pkg::*;
#(
    parameter int          FIFO_DEPTH = 8,
    parameter int          POS_W      = 13,
    parameter int          CRC_W      = 6,
    parameter int          EDGE_W     = 8,
    parameter logic [7:0]  VER_MAJOR  = 8'h01,
    parameter logic [7:0]  VER_MINOR  = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_strobe,
    input  logic [31:0]       rx_word,
    input  logic              tx_pop,
    output logic [31:0]       tx_word,
    output logic              data_ready,
    output logic              enc_launch,
    input  logic              enc_done,
    input  logic [POS_W-1:0]  enc_gray,
    input  logic [1:0]        enc_flags,
    input  logic [CRC_W-1:0]  enc_crc_rx,
    input  logic [CRC_W-1:0]  enc_crc_calc,
    input  logic [EDGE_W-1:0] enc_edges
);
    localparam int POS_PAD  = 16 - POS_W;
    localparam int CRC_PAD  = 8 - CRC_W;
    localparam int EDGE_PAD = 8 - EDGE_W;

    disp_state_t state_q, state_d;

    logic [POS_W-1:0]  cap_gray;
    logic [POS_W-1:0]  cap_bin;
    logic [1:0]        cap_flags;
    logic [CRC_W-1:0]  cap_crc_rx, cap_crc_calc;
    logic [EDGE_W-1:0] cap_edges;

    logic        fifo_push, fifo_empty, fifo_full;
    logic [31:0] fifo_data;
    logic [7:0]  cmd;
    logic        idle_cmd;

    assign cmd        = rx_word[31:24];
    assign idle_cmd   = rx_strobe && (state_q == ST_IDLE);
    assign data_ready = !fifo_empty;

    enclink_gray_to_bin #(.W(POS_W)) u_g2b (
        .gray (cap_gray),
        .bin  (cap_bin)
    );

    enclink_reply_fifo #(.DEPTH(FIFO_DEPTH), .DW(32)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (fifo_push),
        .push_data (fifo_data),
        .pop       (tx_pop),
        .head      (tx_word),
        .empty     (fifo_empty),
        .full      (fifo_full)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (enc_launch) state_d = ST_WAIT_ENC;
            ST_WAIT_ENC: if (enc_done)   state_d = ST_Q_RAW;
            ST_Q_RAW:    state_d = ST_Q_BIN;
            ST_Q_BIN:    state_d = ST_Q_STAT;
            ST_Q_STAT:   state_d = ST_Q_EDGE;
            ST_Q_EDGE:   state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // frame capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_gray     <= '0;
            cap_flags    <= '0;
            cap_crc_rx   <= '0;
            cap_crc_calc <= '0;
            cap_edges    <= '0;
        end else if (state_q == ST_WAIT_ENC && enc_done) begin
            cap_gray     <= enc_gray;
            cap_flags    <= enc_flags;
            cap_crc_rx   <= enc_crc_rx;
            cap_crc_calc <= enc_crc_calc;
            cap_edges    <= enc_edges;
        end
    end

    // outputs
    always_comb begin
        enc_launch = 1'b0;
        fifo_push  = 1'b0;
        fifo_data  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (idle_cmd && cmd == CMD_READ && fifo_empty) begin
                    enc_launch = 1'b1;
                end else if (idle_cmd && cmd == CMD_VERSION && !fifo_full) begin
                    fifo_push = 1'b1;
                    fifo_data = {CMD_VERSION, 8'h00, VER_MAJOR, VER_MINOR};
                end else if (idle_cmd && cmd == CMD_PROTO && !fifo_full) begin
                    fifo_push = 1'b1;
                    fifo_data = PROTO_WORD;
                end
            end
            ST_WAIT_ENC: ;
            ST_Q_RAW: begin
                fifo_push = 1'b1;
                fifo_data = {TAG_RAW, 8'h00, {POS_PAD{1'b0}}, cap_gray};
            end
            ST_Q_BIN: begin
                fifo_push = 1'b1;
                fifo_data = {TAG_BIN, 8'h00, {POS_PAD{1'b0}}, cap_bin};
            end
            ST_Q_STAT: begin
                fifo_push = 1'b1;
                fifo_data = {TAG_STAT, 6'b0, cap_flags,
                             {CRC_PAD{1'b0}}, cap_crc_rx,
                             {CRC_PAD{1'b0}}, cap_crc_calc};
            end
            ST_Q_EDGE: begin
                fifo_push = 1'b1;
                fifo_data = {TAG_EDGE, 16'h0000, {EDGE_PAD{1'b0}}, cap_edges};
            end
            default: ;
        endcase
    end

    assert_launch_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        enc_launch |=> !enc_launch)
        else $error("launch strobe longer than one cycle");

    assert_no_launch_pending_R10: assert property (@(posedge clk) disable iff (!rst_n)
        enc_launch |-> !data_ready)
        else $error("read launched while answers are pending");

    assert_empty_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !data_ready |-> (tx_word == 32'h0))
        else $error("nonzero outgoing word with empty FIFO");
endmodule

// File: tb/enclink_cmd_dispatch_test.sv
`timescale 1ns/1ps
module enclink_cmd_dispatch_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_strobe = 1'b0;
    logic [31:0] rx_word = '0;
    logic        tx_pop = 1'b0;
    logic [31:0] tx_word;
    logic        data_ready;
    logic        enc_launch;
    logic        enc_done = 1'b0;
    logic [12:0] enc_gray = '0;
    logic [1:0]  enc_flags = '0;
    logic [5:0]  enc_crc_rx = '0;
    logic [5:0]  enc_crc_calc = '0;
    logic [7:0]  enc_edges = '0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    enclink_cmd_dispatch uut (
        .clk(clk), .rst_n(rst_n), .rx_strobe(rx_strobe), .rx_word(rx_word),
        .tx_pop(tx_pop), .tx_word(tx_word), .data_ready(data_ready),
        .enc_launch(enc_launch), .enc_done(enc_done), .enc_gray(enc_gray),
        .enc_flags(enc_flags), .enc_crc_rx(enc_crc_rx),
        .enc_crc_calc(enc_crc_calc), .enc_edges(enc_edges)
    );

    function automatic logic [12:0] exp_bin(input logic [12:0] g);
        logic [12:0] b = '0;
        for (int k = 0; k < 13; k++) b = b ^ (g >> k);
        return b;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // drive a datagram at a falling edge; returns launch seen in that cycle
    task automatic send(input logic [31:0] w, output logic launched);
        @(negedge clk);
        rx_strobe = 1'b1;
        rx_word   = w;
        #0.5;
        launched = enc_launch;
        @(negedge clk);
        rx_strobe = 1'b0;
        rx_word   = '0;
        #0.5;
    endtask

    task automatic pop_chk(input string req, input logic [31:0] exp);
        @(negedge clk);
        chk(req, tx_word, exp);
        tx_pop = 1'b1;
        @(negedge clk);
        tx_pop = 1'b0;
    endtask

    task automatic enc_reply(input logic [12:0] g, input logic [1:0] f,
                             input logic [5:0] cr, input logic [5:0] cc,
                             input logic [7:0] e);
        repeat (3) @(negedge clk);
        enc_gray = g; enc_flags = f; enc_crc_rx = cr; enc_crc_calc = cc; enc_edges = e;
        enc_done = 1'b1;
        @(negedge clk);
        enc_done = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    task automatic full_read(input logic [12:0] g, input logic [1:0] f,
                             input logic [5:0] cr, input logic [5:0] cc,
                             input logic [7:0] e);
        logic l;
        send({8'h80, 24'($urandom)}, l);
        chk("R2 launch on read", 32'(l), 32'd1);
        @(negedge clk);
        chk("R2 launch single cycle", 32'(enc_launch), 32'd0);
        enc_reply(g, f, cr, cc, e);
        chk("R7 ready after read", 32'(data_ready), 32'd1);
        pop_chk("R3 raw word", {8'h10, 8'h00, 3'b0, g});
        pop_chk("R4 binary word", {8'h20, 8'h00, 3'b0, exp_bin(g)});
        pop_chk("R3 status word", {8'h70, 6'b0, f, 2'b0, cr, 2'b0, cc});
        pop_chk("R3 edge word", {8'h71, 16'h0, e});
        #0.5;
        chk("R7 ready drops", 32'(data_ready), 32'd0);
        chk("R7 zero when empty", tx_word, 32'h0);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                errors++;
                $display("FAIL watchdog: actual %0d expected below 150000", cycles);
                finish_run();
            end
        end
    end

    initial begin
        logic l;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk("R1 ready low", 32'(data_ready), 32'd0);
        chk("R1 tx zero", tx_word, 32'h0);
        chk("R1 launch low", 32'(enc_launch), 32'd0);
        rst_n = 1'b1;

        // R5 / R6 queries
        send(32'hFF00_0000, l);
        chk("R5 no launch", 32'(l), 32'd0);
        send(32'hFE12_3456, l);
        chk("R8 ready with two", 32'(data_ready), 32'd1);
        pop_chk("R5 version word", 32'hFF00_0100);
        pop_chk("R6 protocol word", 32'h4249_5353);
        #0.5;
        chk("R7 ready drops", 32'(data_ready), 32'd0);

        // R9 dummy and unknown
        send(32'h0000_0000, l);
        send(32'h3CFF_FFFF, l);
        send(32'h81AB_CDEF, l);
        chk("R9 no launch on unknown", 32'(l), 32'd0);
        chk("R9 nothing queued", 32'(data_ready), 32'd0);
        chk("R9 tx zero", tx_word, 32'h0);

        // directed reads: corners of the position range
        full_read(13'h1FFF, 2'b11, 6'h3F, 6'h3F, 8'd54);
        full_read(13'h0000, 2'b00, 6'h00, 6'h01, 8'd52);
        full_read(13'h1000, 2'b10, 6'h15, 6'h2A, 8'd255);

        // R10 read ignored while FIFO holds words
        send(32'hFF00_0000, l);
        send(32'h8000_0000, l);
        chk("R10 no launch when pending", 32'(l), 32'd0);
        pop_chk("R10 only version queued", 32'hFF00_0100);
        #0.5;
        chk("R10 no extra words", 32'(data_ready), 32'd0);

        // R10 commands ignored while read in flight
        send(32'h8000_0000, l);
        chk("R2 launch", 32'(l), 32'd1);
        send(32'h8000_0000, l);
        chk("R10 second read ignored", 32'(l), 32'd0);
        send(32'hFE00_0000, l);
        chk("R10 query ignored in flight", 32'(data_ready), 32'd0);
        enc_reply(13'h0ABC, 2'b01, 6'h07, 6'h07, 8'd60);
        pop_chk("R3 raw word", {16'h1000, 3'b0, 13'h0ABC});
        pop_chk("R4 binary word", {16'h2000, 3'b0, exp_bin(13'h0ABC)});
        pop_chk("R3 status word", {8'h70, 8'h01, 8'h07, 8'h07});
        // R8 last read-out carries the next command
        @(negedge clk);
        chk("R3 edge word", tx_word, 32'h7100_003C);
        tx_pop = 1'b1; rx_strobe = 1'b1; rx_word = 32'hFF00_0000;
        @(negedge clk);
        tx_pop = 1'b0; rx_strobe = 1'b0; rx_word = '0;
        #0.5;
        chk("R8 pop with command", tx_word, 32'hFF00_0100);
        pop_chk("R8 version after ride-along", 32'hFF00_0100);

        // R11 fill FIFO with queries, then one more
        for (int i = 0; i < 9; i++) send(32'hFE00_0000, l);
        for (int i = 0; i < 8; i++) pop_chk("R11 queued proto", 32'h4249_5353);
        #0.5;
        chk("R11 overflow query dropped", 32'(data_ready), 32'd0);

        // random mix
        for (int it = 0; it < 40; it++) begin
            int op = int'($urandom_range(0, 3));
            if (op == 0) begin
                full_read(13'($urandom), 2'($urandom), 6'($urandom), 6'($urandom), 8'($urandom));
            end else if (op == 1) begin
                send({8'hFF, 24'($urandom)}, l);
                pop_chk("R5 random version", 32'hFF00_0100);
            end else if (op == 2) begin
                send({8'hFE, 24'($urandom)}, l);
                pop_chk("R6 random proto", 32'h4249_5353);
            end else begin
                logic [7:0] t = 8'($urandom);
                if (t == 8'h80 || t == 8'hFF || t == 8'hFE) t = 8'h00;
                send({t, 24'($urandom)}, l);
                chk("R9 random unknown no launch", 32'(l), 32'd0);
                chk("R9 random unknown nothing", 32'(data_ready), 32'd0);
            end
        end
        finish_run();
    end
endmodule